// File: doc/BRIEF.md
# DMA Logical-to-Physical Address Translator

This block sits in front of a DMA engine and turns a logical DMA address into a physical address. The logical space is split into 4 KB pages. Each page has an 8-byte descriptor in a table held in main memory, and the first word of that descriptor holds the physical frame for the page. Software sets the table's physical base and its size in bytes through a small write-only register port. A write to the flush register, whatever its data, discards every translation held on chip.

Translations arrive on a valid/ready request channel and leave on a valid/ready response channel. A four-way fully associative cache holds recently used descriptors and is refilled in round-robin order. A hit answers in the cycle after acceptance. A miss issues one read on a valid/ready memory port and waits for the returned word. The block handles one request at a time. A request is accepted only while `req_ready` is high, and `req_ready` stays low from acceptance until the response has been taken. `rsp_valid`, `rsp_paddr` and `rsp_err` hold steady while `rsp_ready` is low. `mem_rd_valid` and `mem_rd_addr` hold steady while `mem_rd_ready` is low.

A lookup that falls outside the 24-bit logical range, or whose descriptor would lie at or past the table size, gets an error response and causes no memory read. It also sets a sticky fault flag and records the offending address.

Top module: `dma_xlat`

## Requirements
- R1: Page index = logical bits 23:12. The descriptor word is read from base + index*8. The response address is {word bits 28:12, logical bits 11:0}, 29 bits wide. Word bits 31:29 and 11:0 are ignored.
- R2: After reset, the state is as follows: base 0, table size 32768 bytes, cache empty, `err_flag` 0, `req_ready` 1, `rsp_valid` 0, `mem_rd_valid` 0.
- R3: The register select codes are 0 = table base, 1 = table size in bytes and 2 = flush. Select 3 is ignored: it changes no register and flushes nothing.
- R4: A cache hit raises `rsp_valid` in the cycle after the request is accepted and issues no memory read.
- R5: A miss issues exactly one memory read and installs the returned frame. A later lookup of the same page hits.
- R6: The cache holds 4 pages and replaces them in round-robin order. After four misses, the fifth miss evicts the page that was installed first.
- R7: Without a flush, a cached page keeps returning its old frame even if memory changes. Any write to select 2 discards all entries, and the next lookup of each page reads memory again.
- R8: If index*8 >= table size, the response has `rsp_err`=1 and `rsp_paddr`=0, no memory read is made, `err_flag` is set and `err_laddr` records the address. Index*8 = size-8 is still translated.
- R9: A logical address above 0xFFFFFF gives the same error response and fault recording as R8, with no memory read.
- R10: Back-pressure: the response stays valid and stable while `rsp_ready` is low, and the memory request stays stable while `mem_rd_ready` is low.
- R11: `err_flag` stays set once raised until reset. `err_laddr` always holds the most recent faulting address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 base, 1 size, 2 flush, 3 ignored) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_laddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 29 | Physical address, 0 on error |
| rsp_err | output | 1 | Translation fault |
| mem_rd_valid | output | 1 | Descriptor read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_rvalid | input | 1 | Read data returned |
| mem_rd_rdata | input | 32 | Descriptor word |
| err_flag | output | 1 | Sticky fault indication |
| err_laddr | output | 32 | Last faulting logical address |

## Verification
The properties assume that the memory side returns exactly one `mem_rd_rvalid` pulse for each accepted read, and never raises it at any other time. The fill-to-response property only holds under that assumption. The bench's memory model enforces it: it records each read handshake and answers it once, a fixed number of cycles later. Register writes are made only while no translation is in flight, except where a flush is meant to overlap a lookup. The bench reference model tracks base, size and the four cached pages in a queue, so it knows in advance whether each lookup should hit, miss or fault.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_SIZE  = 2'd1,
    CFG_FLUSH = 2'd2,
    CFG_SPARE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/dma_xlat_cfg.sv
module dma_xlat_cfg
  import dma_xlat_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LIMIT_RST = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] size_o,
  output logic          flush_o
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= AW'(LIMIT_RST);
    end else if (cfg_wr) begin
      if (cfg_sel == CFG_BASE) base_q <= cfg_wdata;
      if (cfg_sel == CFG_SIZE) size_q <= cfg_wdata;
    end
  end

  assign base_o  = base_q;
  assign size_o  = size_q;
  assign flush_o = cfg_wr && (cfg_sel == CFG_FLUSH);
endmodule

// File: rtl/dma_xlat_index.sv
module dma_xlat_index #(
  parameter int unsigned REQ_W  = 32,
  parameter int unsigned LA_W   = 24,
  parameter int unsigned PG_SH  = 12,
  parameter int unsigned ENT_SH = 3,
  parameter int unsigned AW     = 32
) (
  input  logic [REQ_W-PG_SH-1:0] page,
  input  logic [AW-1:0]          base,
  input  logic [AW-1:0]          size,
  output logic [LA_W-PG_SH-1:0]  idx,
  output logic                   fault,
  output logic [AW-1:0]          ent_addr
);
  localparam int unsigned IDX_W = LA_W - PG_SH;
  localparam int unsigned OFF_W = IDX_W + ENT_SH;
  localparam int unsigned PGN_W = REQ_W - PG_SH;

  logic          in_range;
  logic [AW-1:0] ent_off;

  assign in_range = (page[PGN_W-1:IDX_W] == '0);
  assign idx      = page[IDX_W-1:0];
  assign ent_off  = {{(AW-OFF_W){1'b0}}, idx, {ENT_SH{1'b0}}};
  assign fault    = !in_range || (ent_off >= size);
  assign ent_addr = base + ent_off;
endmodule

// File: rtl/dma_xlat_cache.sv
module dma_xlat_cache #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = 12,
  parameter int unsigned FRM_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] look_idx,
  output logic             hit,
  output logic [FRM_W-1:0] hit_frm,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [FRM_W-1:0] fill_frm
);
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  match;
  logic [FRM_W-1:0] way_frm [WAYS];
  logic [WAY_W-1:0] rr_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic             v_q;
    logic [IDX_W-1:0] t_q;
    logic [FRM_W-1:0] f_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        f_q <= '0;
      end else if (flush) begin
        v_q <= 1'b0;
      end else if (fill_en && (rr_q == WAY_W'(w))) begin
        v_q <= 1'b1;
        t_q <= fill_idx;
        f_q <= fill_frm;
      end
    end

    assign match[w]   = v_q && (t_q == look_idx);
    assign way_frm[w] = f_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fill_en && !flush) begin
      rr_q <= (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_comb begin
    hit_frm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_frm = hit_frm | way_frm[w];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/dma_xlat_walk.sv
module dma_xlat_walk
  import dma_xlat_pkg::*;
#(
  parameter int unsigned REQ_W = 32,
  parameter int unsigned PA_W  = 29,
  parameter int unsigned PG_SH = 12,
  parameter int unsigned IDX_W = 12,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [REQ_W-1:0]      req_laddr,
  input  logic                  fault,
  input  logic                  hit,
  input  logic [PA_W-PG_SH-1:0] hit_frm,
  input  logic [IDX_W-1:0]      idx,
  input  logic [AW-1:0]         ent_addr,
  input  logic                  flush,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic                  rsp_err,
  output logic                  mem_rd_valid,
  input  logic                  mem_rd_ready,
  output logic [AW-1:0]         mem_rd_addr,
  input  logic                  mem_rd_rvalid,
  input  logic [DW-1:0]         mem_rd_rdata,
  output logic                  fill_en,
  output logic [IDX_W-1:0]      fill_idx,
  output logic [PA_W-PG_SH-1:0] fill_frm,
  output logic                  err_flag,
  output logic [REQ_W-1:0]      err_laddr
);
  walk_state_e        state_q;
  logic [PA_W-1:0]    paddr_q;
  logic               err_q;
  logic [AW-1:0]      addr_q;
  logic [IDX_W-1:0]   idx_q;
  logic [PG_SH-1:0]   off_q;
  logic               drop_q;
  logic               flag_q;
  logic [REQ_W-1:0]   flt_addr_q;
  logic               unused_rdata;

  assign unused_rdata = ^{mem_rd_rdata[DW-1:PA_W], mem_rd_rdata[PG_SH-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      paddr_q    <= '0;
      err_q      <= 1'b0;
      addr_q     <= '0;
      idx_q      <= '0;
      off_q      <= '0;
      drop_q     <= 1'b0;
      flag_q     <= 1'b0;
      flt_addr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            off_q  <= req_laddr[PG_SH-1:0];
            idx_q  <= idx;
            drop_q <= 1'b0;
            if (fault) begin
              err_q      <= 1'b1;
              paddr_q    <= '0;
              flag_q     <= 1'b1;
              flt_addr_q <= req_laddr;
              state_q    <= ST_RESP;
            end else if (hit) begin
              err_q   <= 1'b0;
              paddr_q <= {hit_frm, req_laddr[PG_SH-1:0]};
              state_q <= ST_RESP;
            end else begin
              err_q   <= 1'b0;
              addr_q  <= ent_addr;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (flush) drop_q <= 1'b1;
          if (mem_rd_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (flush) drop_q <= 1'b1;
          if (mem_rd_rvalid) begin
            paddr_q <= {mem_rd_rdata[PA_W-1:PG_SH], off_q};
            state_q <= ST_RESP;
          end
        end
        default: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_err      = err_q;
  assign mem_rd_valid = (state_q == ST_FETCH);
  assign mem_rd_addr  = addr_q;
  assign fill_en      = (state_q == ST_WAIT) && mem_rd_rvalid && !drop_q && !flush;
  assign fill_idx     = idx_q;
  assign fill_frm     = mem_rd_rdata[PA_W-1:PG_SH];
  assign err_flag     = flag_q;
  assign err_laddr    = flt_addr_q;
endmodule

// File: rtl/dma_xlat.sv
module dma_xlat #(
  parameter int unsigned REQ_W     = 32,
  parameter int unsigned LA_W      = 24,
  parameter int unsigned PA_W      = 29,
  parameter int unsigned PG_SH     = 12,
  parameter int unsigned ENT_SH    = 3,
  parameter int unsigned WAYS      = 4,
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned LIMIT_RST = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [REQ_W-1:0] req_laddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_err,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_rvalid,
  input  logic [DW-1:0]    mem_rd_rdata,
  output logic             err_flag,
  output logic [REQ_W-1:0] err_laddr
);
  localparam int unsigned IDX_W = LA_W - PG_SH;
  localparam int unsigned FRM_W = PA_W - PG_SH;

  logic [AW-1:0]    tbl_base;
  logic [AW-1:0]    tbl_size;
  logic             flush;
  logic [IDX_W-1:0] idx;
  logic             fault;
  logic [AW-1:0]    ent_addr;
  logic             raw_hit;
  logic [FRM_W-1:0] hit_frm;
  logic             fill_en;
  logic [IDX_W-1:0] fill_idx;
  logic [FRM_W-1:0] fill_frm;

  dma_xlat_cfg #(.AW(AW), .LIMIT_RST(LIMIT_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base_o(tbl_base), .size_o(tbl_size), .flush_o(flush)
  );

  dma_xlat_index #(.REQ_W(REQ_W), .LA_W(LA_W), .PG_SH(PG_SH), .ENT_SH(ENT_SH), .AW(AW)) u_index (
    .page(req_laddr[REQ_W-1:PG_SH]), .base(tbl_base), .size(tbl_size),
    .idx(idx), .fault(fault), .ent_addr(ent_addr)
  );

  dma_xlat_cache #(.WAYS(WAYS), .IDX_W(IDX_W), .FRM_W(FRM_W)) u_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .look_idx(idx),
    .hit(raw_hit), .hit_frm(hit_frm),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_frm(fill_frm)
  );

  dma_xlat_walk #(.REQ_W(REQ_W), .PA_W(PA_W), .PG_SH(PG_SH), .IDX_W(IDX_W), .AW(AW), .DW(DW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .fault(fault), .hit(raw_hit && !flush), .hit_frm(hit_frm), .idx(idx),
    .ent_addr(ent_addr), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_frm(fill_frm),
    .err_flag(err_flag), .err_laddr(err_laddr)
  );
endmodule

// File: rtl/dma_xlat_chk.sv
module dma_xlat_chk #(
  parameter int unsigned REQ_W = 32,
  parameter int unsigned LA_W  = 24,
  parameter int unsigned PA_W  = 29,
  parameter int unsigned AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [REQ_W-1:0] req_laddr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_err,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             mem_rd_rvalid,
  input logic             err_flag,
  input logic [REQ_W-1:0] err_laddr
);
  logic take_far;
  assign take_far = req_valid && req_ready && ((req_laddr >> LA_W) != '0);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_err));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_range_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_far |=> rsp_valid && rsp_err && !mem_rd_valid);

  p_fault_record_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_far |=> err_flag && (err_laddr == $past(req_laddr)));

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_paddr == '0);

  p_fill_answers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_rvalid |=> rsp_valid && !rsp_err);
endmodule

bind dma_xlat dma_xlat_chk #(.REQ_W(REQ_W), .LA_W(LA_W), .PA_W(PA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_err(rsp_err), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .mem_rd_rvalid(mem_rd_rvalid),
  .err_flag(err_flag), .err_laddr(err_laddr)
);

// File: tb/dma_xlat_bench.sv
`timescale 1ns/1ps
module dma_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [28:0] rsp_paddr;
  logic        rsp_err;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b1;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_rvalid = 1'b0;
  logic [31:0] mem_rd_rdata = '0;
  logic        err_flag;
  logic [31:0] err_laddr;

  always #4 clk = ~clk;

  dma_xlat u_dma_xlat (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_err(rsp_err),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_rdata(mem_rd_rdata),
    .err_flag(err_flag), .err_laddr(err_laddr)
  );

  // reference state
  logic [31:0] ovr [logic [31:0]];
  logic [31:0] base_m = 32'h0;
  logic [31:0] size_m = 32'd32768;
  logic [11:0] cq_idx [$];
  logic [16:0] cq_frm [$];
  bit          exp_fetch = 1'b0;
  int          checks = 0;
  int          fails = 0;
  int          mon_checks = 0;
  int          mon_fails = 0;
  int          reads = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] pend_addr = '0;
  int          pend_cnt = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (ovr.exists(a)) return ovr[a];
    return {3'b111, 5'b0, a[14:3], 12'h0A5};
  endfunction

  // memory model: one answer per accepted read, three cycles later
  always @(negedge clk) begin
    mem_rd_rvalid <= 1'b0;
    if (pend_cnt != 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        mem_rd_rvalid <= 1'b1;
        mem_rd_rdata  <= mem_word(pend_addr);
      end
    end else if (mem_rd_valid && mem_rd_ready) begin
      pend_addr <= mem_rd_addr;
      last_addr <= mem_rd_addr;
      pend_cnt  <= 3;
      reads     <= reads + 1;
    end
  end

  // per-clock comparison against the reference expectations
  logic        hold_prev = 1'b0;
  logic [28:0] pa_prev = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (hold_prev) begin
        mon_checks++;
        if (!rsp_valid || rsp_paddr !== pa_prev) begin
          mon_fails++;
          $display("FAIL R10 response moved under back-pressure: actual %h expected %h", rsp_paddr, pa_prev);
        end
      end
      if (mem_rd_valid) begin
        mon_checks++;
        if (!exp_fetch) begin
          mon_fails++;
          $display("FAIL R4 unexpected memory read: actual %h expected none", mem_rd_addr);
        end
      end
    end
    hold_prev = rsp_valid && !rsp_ready;
    pa_prev   = rsp_paddr;
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    case (sel)
      2'd0: base_m = d;
      2'd1: size_m = d;
      2'd2: begin cq_idx.delete(); cq_frm.delete(); end
      default: ;
    endcase
  endtask

  task automatic xlate(input logic [31:0] la, input bit hold, input string tag);
    logic [11:0] idx;
    logic [31:0] eaddr, w, exp_pa;
    bit          err, hit;
    int          pos, r0, cyc;
    idx   = la[23:12];
    err   = (la > 32'h00FF_FFFF) || ({17'b0, idx, 3'b0} >= size_m);
    eaddr = base_m + {17'b0, idx, 3'b0};
    pos   = -1;
    for (int k = 0; k < cq_idx.size(); k++) if (cq_idx[k] == idx) pos = k;
    hit = !err && (pos >= 0);
    w   = mem_word(eaddr);
    if (err)      exp_pa = 32'h0;
    else if (hit) exp_pa = {3'b0, cq_frm[pos], la[11:0]};
    else          exp_pa = {3'b0, w[28:12], la[11:0]};
    exp_fetch = !err && !hit;
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b1; req_laddr = la;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
    check(tag, "rsp_err", {31'b0, rsp_err}, {31'b0, err});
    check(tag, "rsp_paddr", {3'b0, rsp_paddr}, exp_pa);
    if (exp_fetch) begin
      check("R5", "memory reads per miss", reads - r0, 1);
      check("R1", "descriptor address", last_addr, eaddr);
      if (cq_idx.size() == 4) begin void'(cq_idx.pop_front()); void'(cq_frm.pop_front()); end
      cq_idx.push_back(idx);
      cq_frm.push_back(w[28:12]);
    end else begin
      check(err ? tag : "R4", "response latency", cyc, 1);
      check(err ? tag : "R4", "memory reads", reads - r0, 0);
    end
    if (err) begin
      check("R11", "err_flag", {31'b0, err_flag}, 32'd1);
      check("R11", "err_laddr", err_laddr, la);
    end
    if (hold) begin
      rsp_ready = 1'b0;
      repeat (3) @(negedge clk);
      check("R10", "valid under back-pressure", {31'b0, rsp_valid}, 32'd1);
      check("R10", "paddr under back-pressure", {3'b0, rsp_paddr}, exp_pa);
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    exp_fetch = 1'b0;
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "req_ready", {31'b0, req_ready}, 32'd1);
    check("R2", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R2", "mem_rd_valid", {31'b0, mem_rd_valid}, 32'd0);
    check("R2", "err_flag", {31'b0, err_flag}, 32'd0);

    ovr[32'h2D0] = {3'b101, 17'h1FFFF, 12'h3C3};
    xlate(32'h0000_0123, 1'b0, "R5");      // miss, identity page 0
    xlate(32'h0000_0FFF, 1'b0, "R4");      // hit
    xlate(32'h0005_A7C3, 1'b0, "R1");      // top frame, junk bits ignored
    xlate(32'h0000_1004, 1'b0, "R5");
    xlate(32'h0000_2008, 1'b0, "R5");
    xlate(32'h0000_300C, 1'b0, "R6");      // evicts page 0
    xlate(32'h0000_0010, 1'b0, "R6");      // page 0 misses again, evicts page 0x5A
    xlate(32'h0005_A000, 1'b0, "R6");      // misses, evicts page 1
    xlate(32'h0000_2FF0, 1'b0, "R6");      // still cached

    ovr[32'h10] = {3'b000, 17'h00777, 12'h000};
    xlate(32'h0000_2ABC, 1'b0, "R7");      // stale frame kept
    cfg(2'd2, 32'hDEAD_BEEF);
    xlate(32'h0000_2ABC, 1'b0, "R7");      // fresh read
    cfg(2'd3, 32'h0000_0000);
    xlate(32'h0000_2111, 1'b0, "R3");      // spare write flushed nothing
    xlate(32'h0000_7222, 1'b0, "R3");      // base unchanged

    cfg(2'd1, 32'h0000_0100);
    xlate(32'h0002_0040, 1'b0, "R8");      // index 32 -> offset 256, fault
    xlate(32'h0001_F040, 1'b0, "R8");      // last entry still translates
    xlate(32'h0100_0000, 1'b0, "R9");      // beyond 24 bits
    cfg(2'd1, 32'd32768);
    xlate(32'h00FF_FFFF, 1'b1, "R9");      // top of range, held response
    check("R11", "flag still set", {31'b0, err_flag}, 32'd1);
    check("R11", "latest fault kept", err_laddr, 32'h0100_0000);

    cfg(2'd0, 32'h0001_0000);
    cfg(2'd2, 32'h0);
    xlate(32'h0000_3456, 1'b1, "R1");      // reads 0x10018
    xlate(32'h0000_3457, 1'b0, "R4");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++; fails++;
      $display("FAIL watchdog: actual expired expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule